// File: doc/BRIEF.md
# I2C Controller Transaction Engine

This block is a single-controller I2C master that runs one complete bus transaction for each command. A command gives a 7-bit target address, a direction, a byte count and, for writes, a stream of data bytes that the engine pulls one at a time. The engine waits for an idle bus and sends a start. It then shifts out the address and direction byte and moves the data bytes in the requested direction, checking or generating the acknowledge on every ninth clock. It ends with a stop or, on request, keeps the bus for a repeated start.

SCL and SDA leave the block as open-drain pull-down enables; the sensed line levels come back in through a two-flop synchronizer. Each SCL period is four quarter-phases of `QTR_CYC` clock cycles. SCL is low in quarters 0 and 1 and released in quarters 2 and 3. SDA moves only at the boundary between quarters 0 and 1. A missing acknowledge from the target ends the transaction at once with a stop and raises a sticky error flag. The last byte of a read is answered with a not-acknowledge, so the target frees SDA before the stop.

Top module: `i2c_xact_engine`

## Requirements
- R1: After reset, and whenever no transaction is running and the bus is not held, both pull-down enables are off, `busy_o` is low and `err_o` is low.
- R2: After a command is accepted from idle, no start is issued until both sensed lines have been high for four consecutive quarter ticks. While SDA is held low by another device, `busy_o` stays high and no start appears.
- R3: A start pulls SDA low while SCL is released, and pulls SCL low two quarters later. Each transaction produces exactly one start, or two when a held bus is reused.
- R4: The first byte after a start carries the 7-bit address MSB first, followed by the direction bit (1 = read, 0 = write).
- R5: SDA never changes while SCL is released, except for a start or stop. One SCL period lasts 4*QTR_CYC clock cycles.
- R6: For a write, `wr_take_o` pulses once for each data byte as it is loaded, and that byte is sent MSB first. On the ninth clock SDA is released and the acknowledge is sampled while SCL is high.
- R7: If SDA is high at the sampled ninth clock of an address or write byte, the engine sends no further bytes, issues a stop and sets `err_o`. `err_o` stays set until the next command is accepted.
- R8: For a read, the engine releases SDA for eight clocks and presents each byte on `rd_byte_o` with a one-cycle `rd_valid_o`. It then drives acknowledge (SDA low) on every byte except the last, which gets a not-acknowledge (SDA released).
- R9: A stop releases SCL while SDA is pulled low, then releases SDA one quarter later. `done_o` is a single-cycle pulse at the end of the transaction.
- R10: A command with `cmd_hold_i` set ends without a stop, with SCL held low, SDA released, `busy_o` low and a `done_o` pulse. The next command then begins with a repeated start.
- R11: A byte count of zero sends the address only and then finishes normally.
- R12: `cmd_go_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_go_i | input | 1 | Command strobe, taken when not busy |
| cmd_addr_i | input | 7 | Target address |
| cmd_read_i | input | 1 | Direction: 1 read, 0 write |
| cmd_len_i | input | LEN_W | Number of data bytes |
| cmd_hold_i | input | 1 | End without a stop and keep the bus |
| wr_byte_i | input | 8 | Next write byte, sampled when loaded |
| wr_take_o | output | 1 | Pulse: `wr_byte_i` was loaded |
| rd_byte_o | output | 8 | Last byte read |
| rd_valid_o | output | 1 | Pulse: `rd_byte_o` is new |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Pulse at the end of a transaction |
| err_o | output | 1 | Sticky missing-acknowledge flag |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The hardest cases to reach are the aborts in the middle of a transaction. For a write-data not-acknowledge, the target has to refuse one particular byte after it has accepted the address and the earlier bytes. For the repeated start, the bus must be left held from a previous command. The bench models a wired-AND bus with a behavioural target that refuses any written byte of value 0xEE, so a write whose second byte is 0xEE aborts partway through. A command with the hold flag, followed by a read, exercises the repeated start. A bench-driven pull-down on SDA keeps the bus busy so that the wait for an idle bus can be observed.

// File: rtl/i2c_xe_pkg.sv
package i2c_xe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREE,
    ST_START,
    ST_BIT,
    ST_STOP,
    ST_HOLD,
    ST_RSTART
  } xe_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned ACK_IDX = BYTE_W;
endpackage

// File: rtl/i2c_xe_sync.sv
module i2c_xe_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b1;
        q_o[g]    <= 1'b1;
      end else begin
        meta_q[g] <= d_i[g];
        q_o[g]    <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/i2c_xe_qtick.sv
module i2c_xe_qtick #(
  parameter int unsigned QTR_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  output logic       tick_o,
  output logic [1:0] q_o
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= '0;
    end else if (!run_i || clr_i) begin
      cnt_q <= '0;
      q_o   <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      q_o   <= q_o + 2'd1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/i2c_xe_shift.sv
module i2c_xe_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (load_i)  data_o <= load_val_i;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_xact_engine.sv
module i2c_xact_engine
  import i2c_xe_pkg::*;
#(
  parameter int unsigned QTR_CYC = 4,
  parameter int unsigned LEN_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_go_i,
  input  logic [6:0]       cmd_addr_i,
  input  logic             cmd_read_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic             cmd_hold_i,
  input  logic [7:0]       wr_byte_i,
  output logic             wr_take_o,
  output logic [7:0]       rd_byte_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             scl_i,
  input  logic             sda_i
);
  localparam logic [3:0] ACK_POS = 4'(ACK_IDX);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  xe_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic rd_q, hold_q, is_addr_q, samp_q;
  logic [LEN_W-1:0] left_q;
  logic [3:0] bit_idx_q;
  logic [1:0] free_q;
  logic scl_low_q, sda_low_q;

  logic scl_s, sda_s;
  logic tick;
  logic [1:0] q;
  logic run, clr;
  logic [BYTE_W-1:0] sh;
  logic sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_val;
  logic tx_phase, nack_seen, more, end_byte, next_wr, at_q3;

  i2c_xe_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  assign run = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign clr = tick && (state_q == ST_FREE) && scl_s && sda_s && (free_q == 2'd3);

  i2c_xe_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (clr),
    .tick_o(tick),
    .q_o   (q)
  );

  // byte decisions made at the end of the ninth clock
  assign tx_phase  = is_addr_q || !rd_q;
  assign nack_seen = tx_phase && samp_q;
  assign more      = is_addr_q ? (left_q != '0) : (left_q != ONE);
  assign at_q3     = tick && (q == 2'd3);
  assign end_byte  = at_q3 && (state_q == ST_BIT) && (bit_idx_q == ACK_POS);
  assign next_wr   = end_byte && !nack_seen && more && !rd_q;

  always_comb begin
    sh_load  = 1'b0;
    sh_val   = {addr_q, rd_q};
    sh_shift = 1'b0;
    if (at_q3 && ((state_q == ST_START) || (state_q == ST_RSTART))) begin
      sh_load = 1'b1;
    end else if (next_wr) begin
      sh_load = 1'b1;
      sh_val  = wr_byte_i;
    end else if (at_q3 && (state_q == ST_BIT) && (bit_idx_q != ACK_POS)) begin
      sh_shift = 1'b1;
    end
  end

  i2c_xe_shift #(.W(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(sh_val),
    .shift_i   (sh_shift),
    .bit_i     (samp_q),
    .data_o    (sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      hold_q     <= 1'b0;
      is_addr_q  <= 1'b0;
      samp_q     <= 1'b1;
      left_q     <= '0;
      bit_idx_q  <= '0;
      free_q     <= '0;
      scl_low_q  <= 1'b0;
      sda_low_q  <= 1'b0;
      err_o      <= 1'b0;
      done_o     <= 1'b0;
      wr_take_o  <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_byte_o  <= '0;
    end else begin
      done_o     <= 1'b0;
      wr_take_o  <= next_wr;
      rd_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (cmd_go_i) begin
            addr_q  <= cmd_addr_i;
            rd_q    <= cmd_read_i;
            hold_q  <= cmd_hold_i;
            left_q  <= cmd_len_i;
            err_o   <= 1'b0;
            free_q  <= '0;
            state_q <= (state_q == ST_IDLE) ? ST_FREE : ST_RSTART;
          end
        end
        ST_FREE: begin
          if (tick) begin
            if (scl_s && sda_s) begin
              if (free_q == 2'd3) state_q <= ST_START;
              else                free_q  <= free_q + 2'd1;
            end else begin
              free_q <= '0;
            end
          end
        end
        ST_START: begin
          if (tick) begin
            unique case (q)
              2'd0: sda_low_q <= 1'b1;
              2'd2: scl_low_q <= 1'b1;
              2'd3: begin
                state_q   <= ST_BIT;
                bit_idx_q <= '0;
                is_addr_q <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_RSTART: begin
          if (tick) begin
            unique case (q)
              2'd0: sda_low_q <= 1'b0;
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b1;
              default: begin
                scl_low_q <= 1'b1;
                state_q   <= ST_BIT;
                bit_idx_q <= '0;
                is_addr_q <= 1'b1;
              end
            endcase
          end
        end
        ST_BIT: begin
          if (tick) begin
            unique case (q)
              2'd0: begin
                if (bit_idx_q != ACK_POS) sda_low_q <= tx_phase ? !sh[BYTE_W-1] : 1'b0;
                else                      sda_low_q <= tx_phase ? 1'b0 : (left_q != ONE);
              end
              2'd1: scl_low_q <= 1'b0;
              2'd2: samp_q <= sda_s;
              default: begin
                scl_low_q <= 1'b1;
                if (bit_idx_q != ACK_POS) begin
                  bit_idx_q <= bit_idx_q + 4'd1;
                end else begin
                  bit_idx_q <= '0;
                  if (nack_seen) begin
                    err_o   <= 1'b1;
                    state_q <= ST_STOP;
                  end else begin
                    if (!is_addr_q) left_q <= left_q - ONE;
                    is_addr_q <= 1'b0;
                    if (!is_addr_q && rd_q) begin
                      rd_byte_o  <= sh;
                      rd_valid_o <= 1'b1;
                    end
                    if (!more) begin
                      if (hold_q) begin
                        state_q <= ST_HOLD;
                        done_o  <= 1'b1;
                      end else begin
                        state_q <= ST_STOP;
                      end
                    end
                  end
                end
              end
            endcase
          end
        end
        ST_STOP: begin
          if (tick) begin
            unique case (q)
              2'd0: sda_low_q <= 1'b1;
              2'd1: scl_low_q <= 1'b0;
              2'd2: sda_low_q <= 1'b0;
              default: begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = run;
  assign scl_oe_o = scl_low_q;
  assign sda_oe_o = sda_low_q;
endmodule

// File: rtl/i2c_xe_chk.sv
module i2c_xe_chk
  import i2c_xe_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input xe_state_e state_i,
  input logic      scl_oe_i,
  input logic      sda_oe_i,
  input logic      sda_i,
  input logic      done_i,
  input logic      err_i,
  input logic      busy_i
);
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_IDLE) || (state_i == ST_FREE)) |-> (!scl_oe_i && !sda_oe_i));

  a_r3_start_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_i) && !scl_oe_i) |-> $past(sda_i));

  a_r5_sda_quiet_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_BIT) && !scl_oe_i && $past(!scl_oe_i)) |-> $stable(sda_oe_i));

  a_r9_stop_scl_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_STOP) && $fell(sda_oe_i)) |-> !scl_oe_i);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r7_err_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> (state_i == ST_STOP));

  a_r10_hold_keeps_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD) |-> (scl_oe_i && !sda_oe_i && !busy_i));
endmodule

bind i2c_xact_engine i2c_xe_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state_q),
  .scl_oe_i(scl_oe_o),
  .sda_oe_i(sda_oe_o),
  .sda_i   (sda_i),
  .done_i  (done_o),
  .err_i   (err_o),
  .busy_i  (busy_o)
);

// File: tb/tb_i2c_xact_engine.sv
module tb_i2c_xact_engine;
  localparam int QTR = 4;
  localparam int LW  = 4;
  localparam logic [6:0] TADDR = 7'h52;
  // {addr7, rd1, len3, seed8, exp_err1, exp_bytes3}
  localparam logic [22:0] VEC [6] = '{
    {7'h52, 1'b0, 3'd2, 8'h5A, 1'b0, 3'd2},
    {7'h52, 1'b1, 3'd3, 8'h00, 1'b0, 3'd3},
    {7'h13, 1'b0, 3'd2, 8'h77, 1'b1, 3'd0},
    {7'h52, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0},
    {7'h52, 1'b0, 3'd3, 8'hDB, 1'b1, 3'd2},
    {7'h52, 1'b1, 3'd1, 8'h00, 1'b0, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_go = 1'b0, cmd_read = 1'b0, cmd_hold = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [7:0] wr_byte = '0;
  logic wr_take, rd_valid, busy, done, err, scl_oe, sda_oe;
  logic [7:0] rd_byte;
  logic tgt_low = 1'b0, hog_low = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || tgt_low || hog_low);

  always #4 clk = !clk;

  i2c_xact_engine #(.QTR_CYC(QTR), .LEN_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_go_i(cmd_go), .cmd_addr_i(cmd_addr),
    .cmd_read_i(cmd_read), .cmd_len_i(cmd_len), .cmd_hold_i(cmd_hold),
    .wr_byte_i(wr_byte), .wr_take_o(wr_take), .rd_byte_o(rd_byte),
    .rd_valid_o(rd_valid), .busy_o(busy), .done_o(done), .err_o(err),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .scl_i(scl_bus), .sda_i(sda_bus)
  );

  int checks = 0, fails = 0;
  int start_cnt = 0, stop_cnt = 0, wcnt = 0, rcnt = 0, rdn = 0, takes = 0, wr_idx = 0;
  logic [7:0] cur_seed = '0;
  logic [7:0] wlog [16];
  logic [7:0] rbuf [16];
  logic mack [16];
  logic [7:0] t_abyte = '0;
  time last_rise = 0, last_gap = 0;

  function automatic logic [7:0] wd(input logic [7:0] s, input int k);
    return s + 8'(k) * 8'h13;
  endfunction
  function automatic logic [7:0] rd_pat(input int k);
    return 8'h5A ^ (8'(k) * 8'h27);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // behavioural target on the wired-AND bus
  int t_mode = 0, t_bit = 0;
  logic [7:0] t_sh = '0;
  logic t_rw = 1'b0, t_mack = 1'b0;

  always @(negedge sda_bus) if (scl_bus) begin
    start_cnt++; t_mode = 1; t_bit = -1; tgt_low = 1'b0;
  end
  always @(posedge sda_bus) if (scl_bus) begin
    stop_cnt++; t_mode = 0; tgt_low = 1'b0;
  end
  always @(posedge scl_bus) begin
    last_gap = $time - last_rise;
    last_rise = $time;
    if ((t_mode == 1 || t_mode == 2) && t_bit >= 0 && t_bit < 8) t_sh = {t_sh[6:0], sda_bus};
    if (t_mode == 3 && t_bit == 8) t_mack = sda_bus;
  end
  always @(negedge scl_bus) if (t_mode != 0 && t_mode != 4) begin
    t_bit++;
    if (t_bit == 8) begin
      if (t_mode == 1) begin
        t_abyte = t_sh;
        if (t_sh[7:1] == TADDR) begin tgt_low = 1'b1; t_rw = t_sh[0]; end
        else t_mode = 4;
      end else if (t_mode == 2) begin
        wlog[wcnt] = t_sh; wcnt++;
        tgt_low = (t_sh != 8'hEE);
      end else tgt_low = 1'b0;
    end else if (t_bit == 9) begin
      t_bit = 0;
      if (t_mode == 1) begin
        if (t_rw) begin t_mode = 3; tgt_low = !rd_pat(rcnt)[7]; end
        else begin t_mode = 2; tgt_low = 1'b0; end
      end else if (t_mode == 2) tgt_low = 1'b0;
      else begin
        mack[rcnt] = t_mack; rcnt++;
        if (t_mack) begin t_mode = 4; tgt_low = 1'b0; end
        else tgt_low = !rd_pat(rcnt)[7];
      end
    end else if (t_mode == 3 && t_bit > 0) tgt_low = !rd_pat(rcnt)[7 - t_bit];
  end

  // write-data feeder and read capture
  initial forever begin
    @(negedge clk);
    if (wr_take) begin takes++; wr_idx++; wr_byte = wd(cur_seed, wr_idx); end
    if (rd_valid) begin rbuf[rdn] = rd_byte; rdn++; end
  end

  task automatic clear_counts();
    start_cnt = 0; stop_cnt = 0; wcnt = 0; rcnt = 0; rdn = 0; takes = 0;
  endtask

  task automatic issue(input logic [6:0] a, input logic r, input logic [LW-1:0] n,
                       input logic h, input logic [7:0] s);
    cur_seed = s; wr_idx = 0; wr_byte = wd(s, 0);
    @(negedge clk);
    cmd_addr = a; cmd_read = r; cmd_len = n; cmd_hold = h; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done, {tag, " done pulse"}, int'(done), 1);
    @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all requirements act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !err && !done, "R1 busy/err/done low after reset", {busy, err, done}, 0);

    // table-driven transactions
    for (int i = 0; i < 6; i++) begin
      logic [6:0] va; logic vr; logic [2:0] vn; logic [7:0] vs; logic ve; logic [2:0] vb;
      {va, vr, vn, vs, ve, vb} = VEC[i];
      repeat (20) @(negedge clk);
      clear_counts();
      issue(va, vr, LW'(vn), 1'b0, vs);
      if (i == 5) chk(!err, "R7 err cleared by next command", int'(err), 0);
      wait_done("R9");
      chk(err == ve, "R7 err flag after transaction", int'(err), int'(ve));
      chk(start_cnt == 1 && stop_cnt == 1, "R3/R9 one start and one stop",
          start_cnt * 16 + stop_cnt, 17);
      chk(t_abyte == {va, vr}, "R4 address byte and direction", t_abyte, {va, vr});
      chk(!scl_oe && !sda_oe && !busy, "R1 released after stop", {scl_oe, sda_oe, busy}, 0);
      if (!vr) begin
        chk(wcnt == int'(vb), "R6/R7 bytes received by target", wcnt, int'(vb));
        chk(takes == int'(vb), "R6 wr_take pulses", takes, int'(vb));
        for (int k = 0; k < int'(vb); k++)
          chk(wlog[k] == wd(vs, k), "R6 write byte value", wlog[k], wd(vs, k));
      end else begin
        chk(rdn == int'(vb), "R8 read bytes delivered", rdn, int'(vb));
        for (int k = 0; k < int'(vb); k++) begin
          chk(rbuf[k] == rd_pat(k), "R8 read byte value", rbuf[k], rd_pat(k));
          chk(mack[k] == (k == int'(vb) - 1), "R8 ack/nack on read byte",
              int'(mack[k]), int'(k == int'(vb) - 1));
        end
      end
      if (i == 0) chk(last_gap == time'(4 * QTR * 8), "R5 SCL period", int'(last_gap), 4 * QTR * 8);
      if (i == 3) chk(wcnt == 0 && takes == 0, "R11 address only", wcnt + takes, 0);
    end

    // R2 wait for free bus
    repeat (10) @(negedge clk);
    hog_low = 1'b1;
    #1;
    clear_counts();
    issue(TADDR, 1'b0, LW'(1), 1'b0, 8'h21);
    repeat (200) @(negedge clk);
    chk(start_cnt == 0 && busy, "R2 no start while SDA held low", start_cnt, 0);
    hog_low = 1'b0;
    #1;
    clear_counts();
    wait_done("R2");
    chk(start_cnt == 1 && wcnt == 1 && wlog[0] == 8'h21, "R2 start after bus frees",
        start_cnt, 1);

    // R10 hold then repeated start
    repeat (10) @(negedge clk);
    clear_counts();
    issue(TADDR, 1'b0, LW'(1), 1'b1, 8'h30);
    wait_done("R10");
    chk(stop_cnt == 0 && start_cnt == 1, "R10 no stop when held", stop_cnt, 0);
    chk(scl_oe && !sda_oe && !busy, "R10 SCL held low, idle", {scl_oe, sda_oe, busy}, 3'b100);
    repeat (30) @(negedge clk);
    chk(scl_oe && !busy, "R10 bus still held", {scl_oe, busy}, 2'b10);
    issue(TADDR, 1'b1, LW'(2), 1'b0, 8'h00);
    wait_done("R10");
    chk(start_cnt == 2 && stop_cnt == 1, "R10 repeated start then stop",
        start_cnt * 16 + stop_cnt, 33);
    chk(rdn == 2 && rbuf[1] == rd_pat(1), "R10 read after repeated start", rdn, 2);

    // R12 command ignored while busy
    repeat (10) @(negedge clk);
    clear_counts();
    issue(TADDR, 1'b0, LW'(1), 1'b0, 8'h40);
    repeat (50) @(negedge clk);
    cmd_addr = 7'h13; cmd_read = 1'b1; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    wait_done("R12");
    repeat (300) @(negedge clk);
    chk(start_cnt == 1 && wcnt == 1 && wlog[0] == 8'h40, "R12 go ignored while busy",
        start_cnt, 1);
    chk(!busy && !scl_oe, "R12 idle after", {busy, scl_oe}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule